// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block decides, every cycle, how the execute stage of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) gets its two source operands, and whether the instruction in decode must wait. It compares the two source register numbers of the decode instruction with the destination numbers of the instructions now in execute, memory and writeback. From that comparison it produces a stall request, plus the operand selects that the execute stage will use on the next cycle. Register operands are read in decode and consumed at the start of execute.

Two bypass paths feed the execute operand muxes. One carries the result latched at the end of execute, from the producer that is then in the memory stage. The other carries the result latched at the end of memory, from the producer that is then in writeback. A run-time mode input sets which producers may use these paths: every producer, load producers only, or none. The stall rules follow the mode, so any value that cannot be forwarded is waited for until the register file holds it. A parameter states whether the register file passes a write through to a read in the same cycle. Without that pass-through, a producer in writeback is one more reason to wait.

While the stall request is high, the surrounding pipeline holds the program counter and the decode register, and it puts a bubble with every write-enable cleared into execute. The selects are worked out one cycle early, in decode, and are registered. The execute stage therefore gets them straight from a flop.

Top module: `hz_bypass_unit`

## Requirements
- R1: While reset is asserted, and until the first forwarding decision after it, both operand selects read 2'b00 (register file). The selects only ever take the values 2'b00 (register file), 2'b01 (end-of-execute result, producer in memory) and 2'b10 (end-of-memory result, producer in writeback).
- R2: In mode 2'b00 (full forwarding), a non-load producer in execute whose destination matches a decode source causes no stall. On the next cycle that operand's select is 2'b01.
- R3: In mode 2'b00, a producer in memory (load or not) that matches a decode source causes no stall. On the next cycle that operand's select is 2'b10.
- R4: When the producers in execute and in memory both match the same source, the producer in execute (the younger one) decides: the next select is 2'b01.
- R5: A load in execute that matches a decode source always raises the stall for one cycle, in every mode. In modes 2'b00 and 2'b01, the consumer then takes the loaded value with select 2'b10.
- R6: In mode 2'b01 (loads only), a non-load result is never forwarded. A matching non-load producer in execute or memory stalls the consumer, and a matching load in memory is forwarded with select 2'b10.
- R7: In modes 2'b10 and 2'b11 (no forwarding), both selects stay 2'b00. With register-file pass-through, an adjacent ALU dependency costs exactly two stall cycles.
- R8: With RF_BYPASS=0, a matching producer in writeback stalls the consumer for one cycle. A consumer three instructions after an ALU producer therefore waits one cycle in every mode. With RF_BYPASS=1, a writeback producer never stalls.
- R9: Register 0 as a source, a producer with destination 0, and a producer with its write-enable low never cause a stall or a forward.
- R10: In the cycle after stall_o is high, both selects are 2'b00, because a bubble occupies execute.
- R11: An older matching producer is ignored when a younger matching producer can be forwarded. A writeback or memory hazard that is shadowed in this way raises no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Forwarding mode: 00 full, 01 loads only, 10/11 none |
| id_rs1_i | input | REG_W | First source register of the decode instruction |
| id_rs2_i | input | REG_W | Second source register of the decode instruction |
| ex_rd_i | input | REG_W | Destination register of the execute instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | REG_W | Destination register of the writeback instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| fwd_a_o | output | 2 | Registered source select for execute operand A |
| fwd_b_o | output | 2 | Registered source select for execute operand B |
| stall_o | output | 1 | Hold fetch and decode, and insert a bubble into execute |

## Verification
The properties take it that the stage inputs describe one pipeline that advances according to stall_o. This means a stalled decode instruction is offered again, and execute holds a bubble with its write-enable low after a stall. They also take it that the mode seen in decode is the mode the forwarding decision belongs to, because every select check looks at the mode one cycle earlier. The bench's sequence replays build exactly such a pipeline in a small shift model driven by the block's own stall output, and each replay keeps the mode constant. The vector table presents each stage state for a single cycle. Every select check in it depends only on the inputs of the cycle just before.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int NUM_OPS  = 2;
    localparam int NUM_PROD = 3;

    localparam int PROD_EX  = 0;
    localparam int PROD_MEM = 1;
    localparam int PROD_WB  = 2;

    localparam logic [1:0] MODE_FULL  = 2'b00;
    localparam logic [1:0] MODE_LOADS = 2'b01;

    typedef enum logic [1:0] {
        SRC_RF    = 2'b00,
        SRC_EXMEM = 2'b01,
        SRC_MEMWB = 2'b10
    } fwd_src_e;

    typedef struct packed {
        fwd_src_e sel_a;
        fwd_src_e sel_b;
    } sel_state_t;

    function automatic logic alu_path_on(input logic [1:0] mode);
        return mode == MODE_FULL;
    endfunction

    function automatic logic load_path_on(input logic [1:0] mode);
        return (mode == MODE_FULL) || (mode == MODE_LOADS);
    endfunction

endpackage

// File: rtl/hz_dep_cmp.sv
module hz_dep_cmp #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic             we_i,
    output logic             hit_o
);

    // A producer only counts when it writes a real (non-zero) register.
    always_comb begin
        hit_o = we_i && (dst_i != '0) && (src_i == dst_i);
    end

endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
    import hz_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit RF_BYPASS = 1'b0
) (
    input  logic [REG_W-1:0]                src_i,
    input  logic [1:0]                      mode_i,
    input  logic [NUM_PROD-1:0][REG_W-1:0]  dst_i,
    input  logic [NUM_PROD-1:0]             we_i,
    input  logic                            ex_load_i,
    input  logic                            mem_load_i,
    output logic                            need_stall_o,
    output fwd_src_e                        sel_o
);

    logic [NUM_PROD-1:0] hit;
    logic                ex_ok;
    logic                mem_ok;
    logic                stall_ex;
    logic                stall_mem;
    logic                stall_wb;

    for (genvar s = 0; s < NUM_PROD; s++) begin : g_cmp
        hz_dep_cmp #(
            .REG_W (REG_W)
        ) u_cmp (
            .src_i (src_i),
            .dst_i (dst_i[s]),
            .we_i  (we_i[s]),
            .hit_o (hit[s])
        );
    end

    // Writeback producer: only a hazard when the register file cannot pass
    // a same-cycle write through to the read, and no younger producer shadows it.
    if (RF_BYPASS) begin : g_wb_thru
        always_comb stall_wb = 1'b0;
    end else begin : g_wb_block
        always_comb stall_wb = hit[PROD_WB] && !hit[PROD_MEM] && !hit[PROD_EX];
    end

    always_comb begin
        // Producer in execute lands on the end-of-execute path next cycle;
        // a load has no data there yet.
        ex_ok  = !ex_load_i && alu_path_on(mode_i);
        // Producer in memory lands on the end-of-memory path next cycle.
        mem_ok = mem_load_i ? load_path_on(mode_i) : alu_path_on(mode_i);

        stall_ex  = hit[PROD_EX] && !ex_ok;
        stall_mem = hit[PROD_MEM] && !hit[PROD_EX] && !mem_ok;

        need_stall_o = stall_ex || stall_mem || stall_wb;

        if (hit[PROD_EX]) begin
            sel_o = SRC_EXMEM;
        end else if (hit[PROD_MEM]) begin
            sel_o = SRC_MEMWB;
        end else begin
            sel_o = SRC_RF;
        end
    end

endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit
    import hz_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter bit RF_BYPASS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [REG_W-1:0] id_rs1_i,
    input  logic [REG_W-1:0] id_rs2_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             ex_we_i,
    input  logic             ex_load_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_we_i,
    input  logic             mem_load_i,
    input  logic [REG_W-1:0] wb_rd_i,
    input  logic             wb_we_i,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o,
    output logic             stall_o
);

    logic [NUM_OPS-1:0][REG_W-1:0]  srcs;
    logic [NUM_PROD-1:0][REG_W-1:0] dsts;
    logic [NUM_PROD-1:0]            wes;
    logic [NUM_OPS-1:0]             need;
    fwd_src_e                       nxt_sel [NUM_OPS];

    sel_state_t st_d;
    sel_state_t st_q;

    assign srcs = {id_rs2_i, id_rs1_i};
    assign dsts = {wb_rd_i, mem_rd_i, ex_rd_i};
    assign wes  = {wb_we_i, mem_we_i, ex_we_i};

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
        hz_src_check #(
            .REG_W     (REG_W),
            .RF_BYPASS (RF_BYPASS)
        ) u_src (
            .src_i        (srcs[op]),
            .mode_i       (mode_i),
            .dst_i        (dsts),
            .we_i         (wes),
            .ex_load_i    (ex_load_i),
            .mem_load_i   (mem_load_i),
            .need_stall_o (need[op]),
            .sel_o        (nxt_sel[op])
        );
    end

    always_comb begin
        stall_o = |need;
        // A stalled decode sends a bubble into execute: its operands are unused.
        st_d.sel_a = stall_o ? SRC_RF : nxt_sel[0];
        st_d.sel_b = stall_o ? SRC_RF : nxt_sel[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel_a: SRC_RF, sel_b: SRC_RF};
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_a_o = st_q.sel_a;
    assign fwd_b_o = st_q.sel_b;

endmodule

// File: rtl/hz_bypass_chk.sv
module hz_bypass_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [REG_W-1:0] id_rs1_i,
    input logic [REG_W-1:0] id_rs2_i,
    input logic [REG_W-1:0] ex_rd_i,
    input logic             ex_we_i,
    input logic             ex_load_i,
    input logic [1:0]       fwd_a_o,
    input logic [1:0]       fwd_b_o,
    input logic             stall_o
);

    // R1
    always_comb begin
        if (rst_n) begin
            legal_sel_chk: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
        end
    end

    // R10
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

    // R5
    load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we_i && ex_load_i && ex_rd_i != '0 &&
         (id_rs1_i == ex_rd_i || id_rs2_i == ex_rd_i)) |-> stall_o);

    // R2
    alu_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && ex_we_i && !ex_load_i && ex_rd_i != '0 &&
         id_rs1_i == ex_rd_i && !stall_o) |=> (fwd_a_o == 2'b01));

    // R9
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1_i == '0) |=> (fwd_a_o == 2'b00));

    // R7
    no_fwd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

    // R6
    loads_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |=> (fwd_a_o != 2'b01 && fwd_b_o != 2'b01));

endmodule

bind hz_bypass_unit hz_bypass_chk #(
    .REG_W (REG_W)
) u_bind_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .id_rs1_i  (id_rs1_i),
    .id_rs2_i  (id_rs2_i),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .fwd_a_o   (fwd_a_o),
    .fwd_b_o   (fwd_b_o),
    .stall_o   (stall_o)
);

// File: tb/hz_bypass_unit_tb.sv
`timescale 1ns/1ps
module hz_bypass_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode;
    logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
    logic       ex_we, ex_ld, mem_we, mem_ld, wb_we;
    logic [1:0] fa, fb, fa_nt, fb_nt;
    logic       st, st_nt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    hz_bypass_unit #(.REG_W(5), .RF_BYPASS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
        .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld),
        .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_ld),
        .wb_rd_i(wb_rd), .wb_we_i(wb_we),
        .fwd_a_o(fa), .fwd_b_o(fb), .stall_o(st)
    );

    hz_bypass_unit #(.REG_W(5), .RF_BYPASS(1'b0)) u_dut_nt (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
        .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld),
        .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_ld),
        .wb_rd_i(wb_rd), .wb_we_i(wb_we),
        .fwd_a_o(fa_nt), .fwd_b_o(fb_nt), .stall_o(st_nt)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] md;
        logic [4:0] rs1, rs2, exrd;
        logic       exwe, exld;
        logic [4:0] memrd;
        logic       memwe, memld;
        logic [4:0] wbrd;
        logic       wbwe;
        logic       exp_st, exp_st_nt;
        logic [1:0] exp_a, exp_b;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R4: execute and memory both match rs1, execute wins
        '{4'd4, 2'b00, 5'd5, 5'd0, 5'd5, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'b01, 2'b00},
        // R11: writeback hazard shadowed by forwardable execute producer
        '{4'd11, 2'b00, 5'd5, 5'd0, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00},
        // R11: writeback hazard shadowed by forwardable memory producer
        '{4'd11, 2'b00, 5'd5, 5'd0, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 2'b10, 2'b00},
        // R9: register zero everywhere
        '{4'd9, 2'b00, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00},
        // R9: matching producers with write-enable low
        '{4'd9, 2'b00, 5'd7, 5'd7, 5'd7, 1'b0, 1'b1, 5'd7, 1'b0, 1'b0, 5'd7, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00},
        // R6: loads-only mode forwards a load in memory on operand B
        '{4'd6, 2'b01, 5'd3, 5'd9, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10},
        // R7: mode 11 behaves as no forwarding, stall then bubble (R10)
        '{4'd7, 2'b11, 5'd4, 5'd0, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00},
        // R6: loads-only mode stalls on an ALU producer in memory
        '{4'd6, 2'b01, 5'd0, 5'd8, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00},
        // R8: writeback-only hazard stalls only without pass-through
        '{4'd8, 2'b00, 5'd12, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00},
        // R2: operand B forwarded from the end-of-execute path
        '{4'd2, 2'b00, 5'd0, 5'd11, 5'd11, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        mode = 2'b00; id_rs1 = '0; id_rs2 = '0;
        ex_rd = '0; ex_we = 1'b0; ex_ld = 1'b0;
        mem_rd = '0; mem_we = 1'b0; mem_ld = 1'b0;
        wb_rd = '0; wb_we = 1'b0;
    endtask

    // Replays producer -> (gap-1 independent) -> consumer of r5 through a
    // shift model of the pipeline that obeys the observed stall output.
    task automatic run_seq(input string req, input logic [1:0] md, input logic ld,
                           input int gap, input bit use_nt, input int exp_st,
                           input logic [1:0] exp_sel);
        logic [4:0] p_rd [8];
        logic [4:0] p_rs [8];
        logic       p_we [8];
        logic       p_ld [8];
        int d, e, m, w, stalls;
        logic [1:0] got_sel;
        logic s;
        for (int k = 0; k < 8; k++) begin
            p_rd[k] = '0; p_rs[k] = '0; p_we[k] = 1'b0; p_ld[k] = 1'b0;
        end
        p_rd[0] = 5'd5; p_we[0] = 1'b1; p_ld[0] = ld;
        for (int k = 1; k < gap; k++) begin
            p_rd[k] = 5'(20 + k); p_we[k] = 1'b1; p_rs[k] = 5'd1;
        end
        p_rd[gap] = 5'd6; p_we[gap] = 1'b1; p_rs[gap] = 5'd5;
        d = 0; e = -1; m = -1; w = -1; stalls = 0; got_sel = 2'b11;
        mode = md;
        for (int cyc = 0; cyc < 12; cyc++) begin
            @(negedge clk);
            id_rs1 = (d >= 0 && d < 8) ? p_rs[d] : '0;
            id_rs2 = '0;
            ex_rd  = (e >= 0 && e < 8) ? p_rd[e] : '0;
            ex_we  = (e >= 0 && e < 8) ? p_we[e] : 1'b0;
            ex_ld  = (e >= 0 && e < 8) ? p_ld[e] : 1'b0;
            mem_rd = (m >= 0 && m < 8) ? p_rd[m] : '0;
            mem_we = (m >= 0 && m < 8) ? p_we[m] : 1'b0;
            mem_ld = (m >= 0 && m < 8) ? p_ld[m] : 1'b0;
            wb_rd  = (w >= 0 && w < 8) ? p_rd[w] : '0;
            wb_we  = (w >= 0 && w < 8) ? p_we[w] : 1'b0;
            if (e == gap) got_sel = use_nt ? fa_nt : fa;
            #1;
            s = use_nt ? st_nt : st;
            if (d == gap && s) stalls++;
            w = m; m = e;
            if (s) begin
                e = -1;
            end else begin
                e = d; d = d + 1;
            end
        end
        check({req, " stall cycles"}, stalls, exp_st);
        check({req, " consumer select"}, int'(got_sel), int'(exp_sel));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset sel a", int'(fa), 0);
        check("R1 reset sel b", int'(fb), 0);
        check("R1 reset stall idle", int'(st), 0);
        rst_n = 1'b1;

        // Vector table
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            mode = VECS[i].md; id_rs1 = VECS[i].rs1; id_rs2 = VECS[i].rs2;
            ex_rd = VECS[i].exrd; ex_we = VECS[i].exwe; ex_ld = VECS[i].exld;
            mem_rd = VECS[i].memrd; mem_we = VECS[i].memwe; mem_ld = VECS[i].memld;
            wb_rd = VECS[i].wbrd; wb_we = VECS[i].wbwe;
            #1;
            check($sformatf("R%0d vec%0d stall", VECS[i].req, i), int'(st), int'(VECS[i].exp_st));
            check($sformatf("R%0d vec%0d stall no-thru", VECS[i].req, i), int'(st_nt), int'(VECS[i].exp_st_nt));
            @(negedge clk);
            check($sformatf("R%0d vec%0d sel a", VECS[i].req, i), int'(fa), int'(VECS[i].exp_a));
            check($sformatf("R%0d vec%0d sel b", VECS[i].req, i), int'(fb), int'(VECS[i].exp_b));
        end

        // Instruction-sequence replays
        run_seq("R2 full alu adjacent",        2'b00, 1'b0, 1, 1'b0, 0, 2'b01);
        run_seq("R3 full alu gap2",            2'b00, 1'b0, 2, 1'b0, 0, 2'b10);
        run_seq("R5 full load-use",            2'b00, 1'b1, 1, 1'b0, 1, 2'b10);
        run_seq("R5 loads-only load-use",      2'b01, 1'b1, 1, 1'b0, 1, 2'b10);
        run_seq("R6 loads-only alu adjacent",  2'b01, 1'b0, 1, 1'b0, 2, 2'b00);
        run_seq("R6 loads-only load gap2",     2'b01, 1'b1, 2, 1'b0, 0, 2'b10);
        run_seq("R7 none alu adjacent",        2'b10, 1'b0, 1, 1'b0, 2, 2'b00);
        run_seq("R7 none alu adjacent no-thru",2'b10, 1'b0, 1, 1'b1, 3, 2'b00);
        run_seq("R8 loads-only alu gap3",      2'b01, 1'b0, 3, 1'b1, 1, 2'b00);
        run_seq("R8 full alu gap3 no-thru",    2'b00, 1'b0, 3, 1'b1, 1, 2'b00);
        run_seq("R8 full alu gap3 thru",       2'b00, 1'b0, 3, 1'b0, 0, 2'b00);

        // R1: reset mid-run clears a live forward select
        @(negedge clk);
        drive_idle();
        id_rs1 = 5'd9; ex_rd = 5'd9; ex_we = 1'b1;
        @(negedge clk);
        check("R2 select before reset", int'(fa), 1);
        rst_n = 1'b0;
        #1;
        check("R1 async reset clears sel a", int'(fa), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive_idle();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule